// File: doc/BRIEF.md
# DMA Interrupt and Error Status Unit

This block keeps the interrupt and error records of a multi-channel DMA controller. The transfer engine and the timeout counters sit elsewhere. They send one-cycle event pulses per channel: a completion pulse, plus four kinds of error pulse (burst timeout, request timeout, transfer error and buffer overflow). The unit latches each pulse into a per-channel sticky status bit. A per-channel mask decides which latched bits reach the two interrupt lines. Completions and errors drive separate interrupt outputs.

Software reaches the unit over a simple 32-bit register bus with byte offsets. Status registers are cleared by writing ones. A global control register holds a unit enable and a self-clearing soft-reset bit. A burst-timeout setting register is also held here, and its enable and count are exported to the timeout logic. Reads return data one cycle after the read strobe.

Top module: `dmairq_hub`

## Requirements
- R1: After reset, all five status registers read 0, the mask register (0x08) reads 0x0000FFFF, control (0x00) reads 0, the burst-timeout setting (0x1C) reads 0, and both interrupt outputs are low.
- R2: While the enable bit (bit 0 of 0x00) is 1, a pulse on bit n of `done_evt` sets bit n of the summary status register at 0x04.
- R3: While enabled, an error pulse on channel n sets bit n of its own error register: burst timeout at 0x0C, request timeout at 0x10, transfer error at 0x14, buffer overflow at 0x18. The same pulse also sets bit n of 0x04.
- R4: Writing a 1 to bit n of any status register clears only bit n. Bits written 0 keep their value.
- R5: If an event arrives in the same cycle as a write-one-to-clear of the same bit, the bit stays set.
- R6: Mask bit n = 1 blocks channel n from `done_irq`, and 0 lets it through. `done_irq` is 1 exactly when some 0x04 bit is set with its mask bit 0. It follows one cycle after the status or mask changes.
- R7: `err_irq` is 1 exactly when some channel has any of its four error bits set with its mask bit 0. It follows one cycle after the change.
- R8: Writing 1 to bit 1 of 0x00 returns the whole unit to the R1 state at that clock edge, and bit 1 always reads 0.
- R9: While the enable bit is 0, event pulses change no status bit.
- R10: The register at 0x1C stores an enable in bit 15 and a 15-bit count in bits 14:0. These drive `btc_en` and `btc_count`, and the other bits read 0.
- R11: `bus_rdata` shows the addressed register one cycle after `bus_rd`. Offsets with no register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| done_evt | input | 16 | Per-channel completion pulses |
| burst_to_evt | input | 16 | Per-channel burst-timeout pulses |
| req_to_evt | input | 16 | Per-channel request-timeout pulses |
| xfer_err_evt | input | 16 | Per-channel transfer-error pulses |
| ovf_evt | input | 16 | Per-channel buffer-overflow pulses |
| done_irq | output | 1 | Combined completion interrupt, registered |
| err_irq | output | 1 | Combined error interrupt, registered |
| dma_en | output | 1 | Unit enable from control bit 0 |
| btc_en | output | 1 | Burst-timeout enable |
| btc_count | output | 15 | Burst-timeout count |

## Verification
A wrong sticky bit shows up in two places. It appears on `bus_rdata` one cycle after a read of the register that holds it. It also appears on an interrupt line one cycle after it is latched, unless the mask blocks it. A wrong mask or a broken error-to-summary link therefore flips `done_irq` or `err_irq` within two cycles of the event. The sweep sends every event kind to every channel with the mask open. Each time it reads all five status registers and both interrupt lines, and then clears the bits. A bit that set on the wrong channel or in the wrong register, or that failed to clear, is caught on that same step.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int N_ERR    = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ERR0 = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_BTC  = 8'h1C;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_RST_BIT = 1;
  localparam int BTC_EN_BIT   = 15;

  // error kinds, in register order starting at OFS_ERR0
  typedef enum int {
    ERR_BURST = 0,
    ERR_REQ   = 1,
    ERR_XFER  = 2,
    ERR_OVF   = 3
  } err_kind_e;

  function automatic logic [ADDR_W-1:0] err_ofs(input int k);
    return ADDR_W'(int'(OFS_ERR0) + 4 * k);
  endfunction
endpackage

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int BTC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_btc,
  input  logic [DATA_W-1:0] wdata,
  output logic              soft_rst,
  output logic              unit_en,
  output logic              btc_en,
  output logic [BTC_W-1:0]  btc_count
);
  // a write with the reset bit set clears everything at this same edge
  assign soft_rst = wr_ctrl & wdata[CTRL_RST_BIT];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      unit_en   <= 1'b0;
      btc_en    <= 1'b0;
      btc_count <= '0;
    end else begin
      if (wr_ctrl) unit_en <= wdata[CTRL_EN_BIT];
      if (wr_btc) begin
        btc_en    <= wdata[BTC_EN_BIT];
        btc_count <= wdata[BTC_W-1:0];
      end
    end
  end

  // R8: a soft reset always leaves the unit disabled
  a_r8_ctrl_cleared: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!unit_en && !btc_en && btc_count == '0));
endmodule

// File: rtl/dmairq_w1c_bank.sv
module dmairq_w1c_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] w1c_vec,
  output logic [W-1:0] bits
);
  always_ff @(posedge clk) begin
    if (clr) bits <= '0;
    else     bits <= (bits & ~w1c_vec) | set_vec;
  end

  // R5: a set in the same cycle survives the clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (clr)
    (set_vec != '0) |=> ((bits & $past(set_vec)) == $past(set_vec)));

  // R4: written ones clear when no event hits them
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (clr)
    ((w1c_vec & ~set_vec) != '0) |=> ((bits & $past(w1c_vec & ~set_vec)) == '0));

  // R4: bits neither written nor set hold
  a_r4_hold: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> ((bits & ~$past(w1c_vec | set_vec)) == ($past(bits) & ~$past(w1c_vec | set_vec))));
endmodule

// File: rtl/dmairq_irq_out.sv
module dmairq_irq_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         wr_mask,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] done_bits,
  input  logic [W-1:0] err_bits,
  output logic [W-1:0] mask,
  output logic         done_irq,
  output logic         err_irq
);
  logic [W-1:0] done_live;
  logic [W-1:0] err_live;

  assign done_live = done_bits & ~mask;
  assign err_live  = err_bits  & ~mask;

  always_ff @(posedge clk) begin
    if (clr) begin
      mask     <= '1;
      done_irq <= 1'b0;
      err_irq  <= 1'b0;
    end else begin
      if (wr_mask) mask <= mask_wdata;
      done_irq <= |done_live;
      err_irq  <= |err_live;
    end
  end

  // R6: a fully masked unit never raises completion
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (clr)
    ((done_bits & ~mask) == '0) |=> !done_irq);

  a_r6_unmasked_fires: assert property (@(posedge clk) disable iff (clr)
    ((done_bits & ~mask) != '0) |=> done_irq);

  // R7: error line follows unmasked error bits
  a_r7_err_follows: assert property (@(posedge clk) disable iff (clr)
    ((err_bits & ~mask) != '0) |=> err_irq);
endmodule

// File: rtl/dmairq_hub.sv
module dmairq_hub
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int BTC_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] done_evt,
  input  logic [NUM_CH-1:0] burst_to_evt,
  input  logic [NUM_CH-1:0] req_to_evt,
  input  logic [NUM_CH-1:0] xfer_err_evt,
  input  logic [NUM_CH-1:0] ovf_evt,
  output logic              done_irq,
  output logic              err_irq,
  output logic              dma_en,
  output logic              btc_en,
  output logic [BTC_W-1:0]  btc_count
);
  logic soft_rst;
  logic clr;
  logic unit_en;

  logic [N_ERR-1:0][NUM_CH-1:0] err_evt_in;
  logic [N_ERR-1:0][NUM_CH-1:0] err_set;
  logic [N_ERR-1:0][NUM_CH-1:0] err_bits;
  logic [NUM_CH-1:0]            err_any;
  logic [NUM_CH-1:0]            stat_set;
  logic [NUM_CH-1:0]            stat_w1c;
  logic [NUM_CH-1:0]            stat_bits;
  logic [NUM_CH-1:0]            mask;
  logic [DATA_W-1:0]            rd_mux;

  assign err_evt_in[ERR_BURST] = burst_to_evt;
  assign err_evt_in[ERR_REQ]   = req_to_evt;
  assign err_evt_in[ERR_XFER]  = xfer_err_evt;
  assign err_evt_in[ERR_OVF]   = ovf_evt;

  dmairq_ctrl #(.BTC_W(BTC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (bus_wr && bus_addr == OFS_CTRL),
    .wr_btc    (bus_wr && bus_addr == OFS_BTC),
    .wdata     (bus_wdata),
    .soft_rst  (soft_rst),
    .unit_en   (unit_en),
    .btc_en    (btc_en),
    .btc_count (btc_count)
  );

  assign clr    = rst | soft_rst;
  assign dma_en = unit_en;

  // error banks, one per kind
  for (genvar k = 0; k < N_ERR; k++) begin : g_err
    logic [NUM_CH-1:0] w1c_k;
    assign err_set[k] = err_evt_in[k] & {NUM_CH{unit_en}};
    assign w1c_k = (bus_wr && bus_addr == err_ofs(k)) ? bus_wdata[NUM_CH-1:0] : '0;
    dmairq_w1c_bank #(.W(NUM_CH)) u_bank (
      .clk     (clk),
      .clr     (clr),
      .set_vec (err_set[k]),
      .w1c_vec (w1c_k),
      .bits    (err_bits[k])
    );
  end

  always_comb begin
    err_any  = '0;
    stat_set = done_evt & {NUM_CH{unit_en}};
    for (int k = 0; k < N_ERR; k++) begin
      err_any  = err_any | err_bits[k];
      stat_set = stat_set | err_set[k];
    end
  end

  assign stat_w1c = (bus_wr && bus_addr == OFS_STAT) ? bus_wdata[NUM_CH-1:0] : '0;

  dmairq_w1c_bank #(.W(NUM_CH)) u_stat (
    .clk     (clk),
    .clr     (clr),
    .set_vec (stat_set),
    .w1c_vec (stat_w1c),
    .bits    (stat_bits)
  );

  dmairq_irq_out #(.W(NUM_CH)) u_irq (
    .clk        (clk),
    .clr        (clr),
    .wr_mask    (bus_wr && bus_addr == OFS_MASK),
    .mask_wdata (bus_wdata[NUM_CH-1:0]),
    .done_bits  (stat_bits),
    .err_bits   (err_any),
    .mask       (mask),
    .done_irq   (done_irq),
    .err_irq    (err_irq)
  );

  // read mux, registered
  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_CTRL)      rd_mux[CTRL_EN_BIT] = unit_en;
    else if (bus_addr == OFS_STAT) rd_mux[NUM_CH-1:0] = stat_bits;
    else if (bus_addr == OFS_MASK) rd_mux[NUM_CH-1:0] = mask;
    else if (bus_addr == OFS_BTC) begin
      rd_mux[BTC_EN_BIT]  = btc_en;
      rd_mux[BTC_W-1:0]   = btc_count;
    end
    for (int k = 0; k < N_ERR; k++)
      if (bus_addr == err_ofs(k)) rd_mux[NUM_CH-1:0] = err_bits[k];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R3: any error event also lands in the summary register
  a_r3_err_to_summary: assert property (@(posedge clk) disable iff (clr)
    (err_set != '0) |=> ((stat_bits & $past(err_set[0] | err_set[1] | err_set[2] | err_set[3]))
                         == $past(err_set[0] | err_set[1] | err_set[2] | err_set[3])));

  // R9: disabled unit gains no new status bits
  a_r9_disabled_no_set: assert property (@(posedge clk) disable iff (clr)
    !unit_en |=> ((stat_bits & ~$past(stat_bits)) == '0 && (err_any & ~$past(err_any)) == '0));

  // R8: soft reset returns status and mask to reset values
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (stat_bits == '0 && err_any == '0 && mask == '1));
endmodule

// File: tb/sim_dmairq_hub.sv
module sim_dmairq_hub;
  localparam int CH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [CH-1:0] done_evt = '0, burst_to_evt = '0, req_to_evt = '0, xfer_err_evt = '0, ovf_evt = '0;
  logic        done_irq, err_irq, dma_en, btc_en;
  logic [14:0] btc_count;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dmairq_hub u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_evt(done_evt),
    .burst_to_evt(burst_to_evt), .req_to_evt(req_to_evt), .xfer_err_evt(xfer_err_evt),
    .ovf_evt(ovf_evt), .done_irq(done_irq), .err_irq(err_irq), .dma_en(dma_en),
    .btc_en(btc_en), .btc_count(btc_count)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // kind 0 = completion, 1..4 = burst, request, transfer, overflow
  task automatic pulse(input int kind, input logic [CH-1:0] v);
    @(negedge clk);
    case (kind)
      0: done_evt = v;
      1: burst_to_evt = v;
      2: req_to_evt = v;
      3: xfer_err_evt = v;
      default: ovf_evt = v;
    endcase
    @(negedge clk);
    done_evt = '0; burst_to_evt = '0; req_to_evt = '0; xfer_err_evt = '0; ovf_evt = '0;
  endtask

  function automatic logic [7:0] eofs(input int k);
    return 8'(12 + 4 * k);
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h04, d); chk("R1 stat", d, 0);
    rd(8'h08, d); chk("R1 mask", d, 32'h0000FFFF);
    for (int k = 0; k < 4; k++) begin rd(eofs(k), d); chk("R1 err", d, 0); end
    rd(8'h1C, d); chk("R1 btc", d, 0);
    chk("R1 irqs", {30'd0, done_irq, err_irq}, 0);

    // R9 disabled: events ignored
    pulse(0, 16'hFFFF); pulse(3, 16'hFFFF);
    rd(8'h04, d); chk("R9 stat", d, 0);
    rd(8'h14, d); chk("R9 xfer", d, 0);

    // enable, open mask
    wr(8'h00, 32'h1); chk("R2 dma_en", {31'd0, dma_en}, 1);
    wr(8'h08, 32'h0);

    // R2/R3/R4/R6/R7 sweep of every channel and kind
    for (int ch = 0; ch < CH; ch++) begin
      for (int kind = 0; kind < 5; kind++) begin
        logic [31:0] bit_v;
        bit_v = 32'(1) << ch;
        pulse(kind, bit_v[CH-1:0]);
        @(negedge clk);
        chk("R6 done_irq", {31'd0, done_irq}, 1);
        chk("R7 err_irq", {31'd0, err_irq}, (kind != 0) ? 1 : 0);
        rd(8'h04, d); chk("R2 R3 summary", d, bit_v);
        for (int k = 0; k < 4; k++) begin
          rd(eofs(k), d); chk("R3 err reg", d, (kind == k + 1) ? bit_v : 0);
        end
        // R4 clearing zeros keeps the bit
        wr(8'h04, ~bit_v);
        rd(8'h04, d); chk("R4 zeros kept", d, bit_v);
        wr(8'h04, bit_v);
        if (kind != 0) wr(eofs(kind - 1), bit_v);
        rd(8'h04, d); chk("R4 cleared", d, 0);
        if (kind != 0) begin rd(eofs(kind - 1), d); chk("R4 err cleared", d, 0); end
        chk("R6 R7 irqs low", {30'd0, done_irq, err_irq}, 0);
      end
    end

    // R5 set wins over clear
    wr(8'h04, 32'h0);
    pulse(0, 16'h0020);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0020; done_evt = 16'h0020;
    @(negedge clk);
    bus_wr = 1'b0; done_evt = '0;
    rd(8'h04, d); chk("R5 set wins", d, 32'h0020);
    wr(8'h04, 32'hFFFF);

    // R6 mask blocks, unmask releases
    wr(8'h08, 32'hFFFF);
    pulse(2, 16'h0008);
    @(negedge clk);
    chk("R6 masked done", {31'd0, done_irq}, 0);
    chk("R7 masked err", {31'd0, err_irq}, 0);
    rd(8'h04, d); chk("R6 still latched", d, 32'h0008);
    wr(8'h08, 32'hFFF7);
    @(negedge clk);
    chk("R6 unmasked done", {31'd0, done_irq}, 1);
    chk("R7 unmasked err", {31'd0, err_irq}, 1);
    rd(8'h08, d); chk("R6 mask readback", d, 32'h0000FFF7);

    // R10 burst-timeout setting
    wr(8'h1C, 32'hFFFF_9234);
    chk("R10 btc_en", {31'd0, btc_en}, 1);
    chk("R10 btc_count", {17'd0, btc_count}, 32'h1234);
    rd(8'h1C, d); chk("R10 readback", d, 32'h0000_9234);

    // R11 unmapped offset
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R11 unmapped", d, 0);
    rd(8'h08, d); chk("R11 no side effect", d, 32'h0000FFF7);

    // R8 soft reset
    wr(8'h00, 32'h3);
    chk("R8 dma_en", {31'd0, dma_en}, 0);
    rd(8'h00, d); chk("R8 ctrl", d, 0);
    rd(8'h04, d); chk("R8 stat", d, 0);
    rd(8'h10, d); chk("R8 req", d, 0);
    rd(8'h08, d); chk("R8 mask", d, 32'h0000FFFF);
    rd(8'h1C, d); chk("R8 btc", d, 0);
    chk("R8 irqs", {30'd0, done_irq, err_irq}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule